// File: doc/BRIEF.md
# Vector Reduction and Prefix-Scan Unit

This unit folds the leading elements of a vector into one scalar, or emits the running partial result at every element position. A command sets the operation (wrapping sum, maximum or minimum), signed or unsigned comparison, reduce or scan mode, and combination order. It also sets a scalar seed and an active length. Element data then streams in as lane groups, one group per handshake, each with a per-lane enable mask. Software that strip-mines a long loop passes the previous chunk's result back in as the next seed. The chained results then equal a single pass over the whole array.

The active length is clamped to the largest supported length. Element `k` (group `k / LANES`, lane `k % LANES`) counts only if its index is below the active length and its mask bit is set. In sequential order the unit folds one lane per cycle in strict index order. In tree order it folds a whole group per cycle through a balanced combining network, or a log-depth prefix network in scan mode. Both orders give bit-identical results. The result is handed over with a valid/ready pair, and a new command is accepted only after the result has been taken.

Top module: `vrs_reduce_scan`

## Requirements
- R1: With op code 0 (sum), the result equals seed plus every contributing element, wrapped modulo 2^W.
- R2: Op code 1 (max) and op code 2 (min) return the largest or smallest of seed and the contributing elements. The comparison is two's-complement when `cmd_signed` is 1 and unsigned when it is 0.
- R3: An element whose mask bit is 0, or whose index is at or beyond the active length, has no effect on the result or on the scan outputs.
- R4: With `cmd_scan` = 1, each consumed group produces one `scan_valid` pulse. Lane j of `scan_data` carries the running value after element j of that group. A non-contributing element repeats the previous running value, and the first running value starts from the seed.
- R5: With an active length of 0, no group is consumed and `res_valid` rises one cycle after command acceptance, with `res_data` equal to the seed.
- R6: With `cmd_tree` = 0 (sequential), a group is folded one lane per cycle, so the result appears G*(LANES+1) cycles after command acceptance for G groups. With `cmd_tree` = 1 it appears after G cycles.
- R7: Sequential and tree order give bit-identical results for identical operands.
- R8: `res_valid` stays high with `res_data` stable until `res_ready`. `cmd_ready` is high only when no operation is in progress and no result is pending.
- R9: An active length above MAX_VL is treated as MAX_VL.
- R10: Exactly ceil(VL/LANES) groups are consumed. `in_ready` is low once the last group has been taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Unit idle, command accepted on this cycle if valid |
| cmd_op | input | 2 | 0 sum, 1 max, 2 min |
| cmd_scan | input | 1 | 1 selects prefix-scan mode |
| cmd_tree | input | 1 | 1 selects tree order, 0 strict sequential order |
| cmd_signed | input | 1 | 1 selects two's-complement compare |
| cmd_seed | input | W | Starting scalar value |
| cmd_vl | input | VLW | Active element count |
| in_valid | input | 1 | Lane group offered |
| in_ready | output | 1 | Lane group accepted on this cycle if valid |
| in_data | input | LANES*W | Lane group, lane j in bits [j*W +: W] |
| in_mask | input | LANES | Per-lane enable |
| scan_valid | output | 1 | One-cycle pulse: scan_data holds one group of prefixes |
| scan_data | output | LANES*W | Running values, lane j in bits [j*W +: W] |
| res_valid | output | 1 | Final scalar available |
| res_ready | input | 1 | Consumer takes the result |
| res_data | output | W | Final scalar |

## Verification
A corrupted accumulator shows up at once in `res_data`, and in scan mode already in the next `scan_data` pulse. In that pulse every later lane of the group inherits the error. A wrong group counter or length compare either leaks elements past the active length into the result, or changes how many groups are taken. The second shows as a wrong `scan_valid` count or a shifted completion cycle. A slip in the sequential lane pointer changes the per-group cycle count and the lane-by-lane prefixes. Sweeping every length, operation, signedness, mode and order against an arithmetic model catches these within one operation.

// File: rtl/vrs_pkg.sv
package vrs_pkg;
  typedef enum logic [1:0] {
    OP_SUM = 2'd0,
    OP_MAX = 2'd1,
    OP_MIN = 2'd2
  } vrs_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } vrs_state_e;
endpackage

// File: rtl/vrs_alu.sv
module vrs_alu
  import vrs_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [1:0]   op,
  input  logic         sgn,
  output logic [W-1:0] y
);
  logic a_gt_b;

  always_comb begin
    a_gt_b = sgn ? ($signed(a) > $signed(b)) : (a > b);
    case (op)
      OP_MAX:  y = a_gt_b ? a : b;
      OP_MIN:  y = a_gt_b ? b : a;
      default: y = a + b;
    endcase
  end
endmodule

// File: rtl/vrs_lane_gate.sv
module vrs_lane_gate
  import vrs_pkg::*;
#(
  parameter int W     = 32,
  parameter int LANES = 4,
  parameter int VLW   = 6,
  parameter int BW    = VLW + 1
) (
  input  logic [LANES-1:0][W-1:0] data,
  input  logic [LANES-1:0]        mask,
  input  logic [BW-1:0]           base,
  input  logic [VLW-1:0]          vl,
  input  logic [1:0]              op,
  input  logic                    sgn,
  output logic [LANES-1:0][W-1:0] gated
);
  localparam logic [W-1:0] MSB_ONLY = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] ident;

  // neutral element of the selected operation
  always_comb begin
    case (op)
      OP_MAX:  ident = sgn ? MSB_ONLY : '0;
      OP_MIN:  ident = sgn ? ~MSB_ONLY : '1;
      default: ident = '0;
    endcase
  end

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic live;
    assign live     = mask[j] && ((base + BW'(j)) < BW'(vl));
    assign gated[j] = live ? data[j] : ident;
  end
endmodule

// File: rtl/vrs_tree_reduce.sv
module vrs_tree_reduce #(
  parameter int W     = 32,
  parameter int LANES = 4
) (
  input  logic [LANES-1:0][W-1:0] lanes,
  input  logic [1:0]              op,
  input  logic                    sgn,
  output logic [W-1:0]            root
);
  localparam int NODES = 2 * LANES - 1;

  // heap layout: node k combines nodes 2k+1 and 2k+2, leaves at the tail
  logic [W-1:0] node [NODES];

  for (genvar j = 0; j < LANES; j++) begin : g_leaf
    assign node[LANES-1+j] = lanes[j];
  end

  for (genvar k = 0; k < LANES - 1; k++) begin : g_inner
    vrs_alu #(.W(W)) alu_i (
      .a  (node[2*k+1]),
      .b  (node[2*k+2]),
      .op (op),
      .sgn(sgn),
      .y  (node[k])
    );
  end

  assign root = node[0];
endmodule

// File: rtl/vrs_prefix_scan.sv
module vrs_prefix_scan #(
  parameter int W     = 32,
  parameter int LANES = 4
) (
  input  logic [LANES-1:0][W-1:0] lanes,
  input  logic [W-1:0]            carry,
  input  logic [1:0]              op,
  input  logic                    sgn,
  output logic [LANES-1:0][W-1:0] pfx
);
  localparam int LV = $clog2(LANES);

  logic [W-1:0] st [LV+1][LANES];

  for (genvar j = 0; j < LANES; j++) begin : g_in
    assign st[0][j] = lanes[j];
  end

  for (genvar l = 0; l < LV; l++) begin : g_lvl
    for (genvar j = 0; j < LANES; j++) begin : g_col
      if (j >= (1 << l)) begin : g_op
        vrs_alu #(.W(W)) alu_i (
          .a  (st[l][j-(1<<l)]),
          .b  (st[l][j]),
          .op (op),
          .sgn(sgn),
          .y  (st[l+1][j])
        );
      end else begin : g_pass
        assign st[l+1][j] = st[l][j];
      end
    end
  end

  for (genvar j = 0; j < LANES; j++) begin : g_out
    vrs_alu #(.W(W)) alu_i (
      .a  (carry),
      .b  (st[LV][j]),
      .op (op),
      .sgn(sgn),
      .y  (pfx[j])
    );
  end
endmodule

// File: rtl/vrs_reduce_scan.sv
module vrs_reduce_scan
  import vrs_pkg::*;
#(
  parameter int W      = 32,
  parameter int LANES  = 4,
  parameter int MAX_VL = 16,
  parameter int VLW    = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [1:0]         cmd_op,
  input  logic               cmd_scan,
  input  logic               cmd_tree,
  input  logic               cmd_signed,
  input  logic [W-1:0]       cmd_seed,
  input  logic [VLW-1:0]     cmd_vl,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [LANES*W-1:0] in_data,
  input  logic [LANES-1:0]   in_mask,
  output logic               scan_valid,
  output logic [LANES*W-1:0] scan_data,
  output logic               res_valid,
  input  logic               res_ready,
  output logic [W-1:0]       res_data
);
  localparam int PW = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int BW = VLW + 1;
  localparam logic [VLW-1:0] VL_CAP = VLW'(MAX_VL);

  vrs_state_e st_q;
  logic [1:0]     op_q;
  logic           scan_q, tree_q, sgn_q, busy_q;
  logic [VLW-1:0] vl_q, vl_eff;
  logic [BW-1:0]  base_q;
  logic [PW-1:0]  ptr_q;
  logic [W-1:0]   acc_q;
  logic [LANES-1:0][W-1:0] lanes_in, gated, hold_q, sbuf_q, pfx, sdata_q;
  logic [W-1:0]   root, acc_tree_n, acc_seq_n;
  logic           sval_q, last_grp;

  assign lanes_in  = in_data;
  assign vl_eff    = (cmd_vl > VL_CAP) ? VL_CAP : cmd_vl;
  assign last_grp  = (base_q + BW'(LANES)) >= BW'(vl_q);

  assign cmd_ready  = (st_q == ST_IDLE);
  assign res_valid  = (st_q == ST_DONE);
  assign res_data   = acc_q;
  assign in_ready   = (st_q == ST_RUN) && (tree_q || !busy_q);
  assign scan_valid = sval_q;
  assign scan_data  = sdata_q;

  vrs_lane_gate #(.W(W), .LANES(LANES), .VLW(VLW), .BW(BW)) gate_i (
    .data (lanes_in),
    .mask (in_mask),
    .base (base_q),
    .vl   (vl_q),
    .op   (op_q),
    .sgn  (sgn_q),
    .gated(gated)
  );

  vrs_tree_reduce #(.W(W), .LANES(LANES)) tree_i (
    .lanes(gated),
    .op   (op_q),
    .sgn  (sgn_q),
    .root (root)
  );

  vrs_prefix_scan #(.W(W), .LANES(LANES)) pfx_i (
    .lanes(gated),
    .carry(acc_q),
    .op   (op_q),
    .sgn  (sgn_q),
    .pfx  (pfx)
  );

  vrs_alu #(.W(W)) fold_tree_i (
    .a(acc_q), .b(root), .op(op_q), .sgn(sgn_q), .y(acc_tree_n)
  );

  vrs_alu #(.W(W)) fold_seq_i (
    .a(acc_q), .b(hold_q[ptr_q]), .op(op_q), .sgn(sgn_q), .y(acc_seq_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      op_q    <= '0;
      scan_q  <= 1'b0;
      tree_q  <= 1'b0;
      sgn_q   <= 1'b0;
      vl_q    <= '0;
      base_q  <= '0;
      ptr_q   <= '0;
      busy_q  <= 1'b0;
      acc_q   <= '0;
      hold_q  <= '0;
      sbuf_q  <= '0;
      sdata_q <= '0;
      sval_q  <= 1'b0;
    end else begin
      sval_q <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (cmd_valid) begin
            op_q   <= cmd_op;
            scan_q <= cmd_scan;
            tree_q <= cmd_tree;
            sgn_q  <= cmd_signed;
            vl_q   <= vl_eff;
            acc_q  <= cmd_seed;
            base_q <= '0;
            ptr_q  <= '0;
            busy_q <= 1'b0;
            st_q   <= (vl_eff == '0) ? ST_DONE : ST_RUN;
          end
        end
        ST_RUN: begin
          if (tree_q) begin
            if (in_valid) begin
              if (scan_q) begin
                acc_q   <= pfx[LANES-1];
                sdata_q <= pfx;
                sval_q  <= 1'b1;
              end else begin
                acc_q <= acc_tree_n;
              end
              base_q <= base_q + BW'(LANES);
              if (last_grp) st_q <= ST_DONE;
            end
          end else if (!busy_q) begin
            if (in_valid) begin
              hold_q <= gated;
              busy_q <= 1'b1;
              ptr_q  <= '0;
            end
          end else begin
            acc_q         <= acc_seq_n;
            sbuf_q[ptr_q] <= acc_seq_n;
            ptr_q         <= ptr_q + 1'b1;
            if (ptr_q == PW'(LANES - 1)) begin
              busy_q <= 1'b0;
              ptr_q  <= '0;
              base_q <= base_q + BW'(LANES);
              if (scan_q) begin
                for (int j = 0; j < LANES; j++)
                  sdata_q[j] <= (j == LANES - 1) ? acc_seq_n : sbuf_q[j];
                sval_q <= 1'b1;
              end
              if (last_grp) st_q <= ST_DONE;
            end
          end
        end
        ST_DONE: begin
          if (res_ready) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vrs_reduce_scan_chk.sv
module vrs_reduce_scan_chk #(
  parameter int W   = 32,
  parameter int VLW = 6
) (
  input logic           clk,
  input logic           rst,
  input logic           cmd_valid,
  input logic           cmd_ready,
  input logic [W-1:0]   cmd_seed,
  input logic [VLW-1:0] cmd_vl,
  input logic           in_valid,
  input logic           in_ready,
  input logic           scan_valid,
  input logic           res_valid,
  input logic           res_ready,
  input logic [W-1:0]   res_data
);
  // R8
  idle_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(cmd_ready && res_valid));

  // R8
  res_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data)));

  // R10
  take_busy_chk: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> (!cmd_ready && !res_valid));

  // R10
  no_idle_after_grp_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !cmd_ready);

  // R4
  scan_in_op_chk: assert property (@(posedge clk) disable iff (rst)
    scan_valid |-> !cmd_ready);

  // R5
  zero_len_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready && (cmd_vl == '0)) |=>
      (res_valid && (res_data == $past(cmd_seed))));
endmodule

bind vrs_reduce_scan vrs_reduce_scan_chk #(.W(W), .VLW(VLW)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_seed  (cmd_seed),
  .cmd_vl    (cmd_vl),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .scan_valid(scan_valid),
  .res_valid (res_valid),
  .res_ready (res_ready),
  .res_data  (res_data)
);

// File: tb/vrs_reduce_scan_tb.sv
module vrs_reduce_scan_tb_top;
  localparam int W = 32, LANES = 4, MAX_VL = 16, VLW = 6;
  localparam int NE = 24;

  logic clk = 1'b0, rst = 1'b1;
  logic cmd_valid = 0, cmd_scan = 0, cmd_tree = 0, cmd_signed = 0;
  logic [1:0] cmd_op = 0;
  logic [W-1:0] cmd_seed = 0;
  logic [VLW-1:0] cmd_vl = 0;
  logic in_valid = 0;
  logic [LANES*W-1:0] in_data = 0;
  logic [LANES-1:0] in_mask = 0;
  logic res_ready = 0;
  logic cmd_ready, in_ready, scan_valid, res_valid;
  logic [LANES*W-1:0] scan_data;
  logic [W-1:0] res_data;

  int n_tests = 0, n_fail = 0, cyc = 0, scan_cnt = 0;
  bit finished = 0, mask_zero = 0;
  logic [LANES*W-1:0] cap [NE];
  logic [W-1:0] elem [NE];
  bit msk [NE];
  logic [W-1:0] sexp [NE];
  logic [31:0] rng;

  vrs_reduce_scan #(.W(W), .LANES(LANES), .MAX_VL(MAX_VL), .VLW(VLW)) dut_i (.*);

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (scan_valid) begin
    if (scan_cnt < NE) cap[scan_cnt] = scan_data;
    scan_cnt++;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] nxt();
    rng = rng * 32'd1664525 + 32'd1013904223;
    return rng;
  endfunction

  function automatic logic [W-1:0] f(input logic [W-1:0] a, b, input int op, input bit sg);
    bit gt;
    gt = sg ? ($signed(a) > $signed(b)) : (a > b);
    case (op)
      1: return gt ? a : b;
      2: return gt ? b : a;
      default: return a + b;
    endcase
  endfunction

  task automatic run_op(input int op, sc, tr, sg, vl, output logic [W-1:0] got);
    int vle, g_n, t0, lat, explat;
    logic [W-1:0] acc, seed;
    string tag;
    rng = 32'h1F2E3D4C ^ (vl * 7919) ^ (op * 131) ^ (sg * 17) ^ (sc * 3);
    seed = nxt();
    for (int i = 0; i < NE; i++) begin
      logic [31:0] r;
      r = nxt();
      elem[i] = nxt();
      msk[i] = !mask_zero && (r[5:4] != 2'b00);
    end
    vle = (vl > MAX_VL) ? MAX_VL : vl;
    g_n = (vle + LANES - 1) / LANES;
    acc = seed;
    for (int i = 0; i < NE; i++) begin
      if (msk[i] && i < vle) acc = f(acc, elem[i], op, sg[0]);
      sexp[i] = acc;
    end
    tag = (vl == 0) ? "R5" : (vl > MAX_VL) ? "R9" : mask_zero ? "R3" : (op == 0) ? "R1" : "R2";
    scan_cnt = 0;
    @(negedge clk);
    cmd_op = op[1:0]; cmd_scan = sc[0]; cmd_tree = tr[0]; cmd_signed = sg[0];
    cmd_seed = seed; cmd_vl = vl[VLW-1:0]; cmd_valid = 1;
    while (!cmd_ready) @(negedge clk);
    @(posedge clk); @(negedge clk);
    cmd_valid = 0;
    t0 = cyc;
    for (int g = 0; g < g_n; g++) begin
      for (int j = 0; j < LANES; j++) begin
        in_data[j*W +: W] = elem[g*LANES+j];
        in_mask[j] = msk[g*LANES+j];
      end
      in_valid = 1;
      while (!in_ready) @(negedge clk);
      @(posedge clk); @(negedge clk);
      in_valid = 0;
    end
    while (!res_valid) @(negedge clk);
    lat = cyc - t0;
    chk(res_data == acc, tag, res_data, acc);
    explat = tr ? g_n : g_n * (LANES + 1);
    chk(lat == explat, "R6", lat, explat);
    chk(!in_ready, "R10", in_ready, 0);
    got = res_data;
    @(negedge clk);
    chk(res_valid && res_data == acc && !cmd_ready, "R8", res_data, acc);
    if (sc) begin
      chk(scan_cnt == g_n, "R4", scan_cnt, g_n);
      for (int g = 0; g < g_n && g < NE; g++)
        for (int j = 0; j < LANES; j++)
          chk(cap[g][j*W +: W] == sexp[g*LANES+j], "R4", cap[g][j*W +: W], sexp[g*LANES+j]);
    end else begin
      chk(scan_cnt == 0, "R4", scan_cnt, 0);
    end
    res_ready = 1;
    @(posedge clk); @(negedge clk);
    res_ready = 0;
    chk(cmd_ready && !res_valid, "R8", {cmd_ready, res_valid}, 2'b10);
  endtask

  initial begin
    logic [W-1:0] r_tree, r_seq;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    chk(cmd_ready && !res_valid && !in_ready && !scan_valid, "R8",
        {cmd_ready, res_valid, in_ready, scan_valid}, 4'b1000);
    for (int vl = 0; vl <= 20; vl++)
      for (int op = 0; op < 3; op++)
        for (int sc = 0; sc < 2; sc++)
          for (int sg = 0; sg < 2; sg++) begin
            run_op(op, sc, 1, sg, vl, r_tree);
            run_op(op, sc, 0, sg, vl, r_seq);
            chk(r_tree == r_seq, "R7", r_seq, r_tree);
          end
    // R3: all lanes masked off leaves the seed untouched
    mask_zero = 1;
    for (int op = 0; op < 3; op++) run_op(op, 1, op % 2, 1, 16, r_tree);
    mask_zero = 0;
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule